// File: doc/BRIEF.md
# PWM-Coded Register Access Master

This block is the controller side of a slow register channel to a serial position sensor that shares one clock output and one data input with the fast sensor traffic. A single request reads or writes one 8-bit register. The block first holds its clock low until the slave pulls the data line low, which confirms the switch to register traffic. It then sends the command bits by changing how long the clock stays high in each period. The slave's reply comes back as plain data, sampled once per clock period.

A read keeps the clock running until the slave raises its start bit. The block then collects eight data bits and a 4-bit check value. A write follows the command with a second start bit, the eight data bits and their check value. The slave returns every bit one period later, and the block compares each returned bit with the one it sent. Each request ends in exactly one response pulse that carries the read data and three status flags.

Top module: `regpwm_master`

## Requirements
- R1: After reset, and between transactions, `bus_clk_o` is high, `req_ready` is high and `rsp_valid` is low. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` stays low until the response.
- R2: Once a request is taken, `bus_clk_o` is held low, one period at a time, until the synchronised `bus_data_i` is seen low at the end of a period. If that does not happen within `cfg_wait` periods, the response carries `rsp_timeout`.
- R3: Each command bit takes one period of `cfg_period` system cycles and starts with its high phase. A 0 is high for floor(P/5) cycles and a 1 is high for P - floor(P/5) cycles.
- R4: The command frame is 16 bits, sent most significant first: a start bit of 1, a 3-bit slave ID, address bits 6 down to 0, a direction bit (1 = write, 0 = read), then a 4-bit check value.
- R5: Every check value uses the generator x^4+x+1. The register starts at 0, bits go in most significant first, and the result is sent without inversion. The command check covers the 11 bits from the ID to the direction bit. The data check covers the 8 data bits.
- R6: The slave ID sent is the parameter ID_BASE (an even value) plus `req_addr[7]`.
- R7: After a read command the clock runs in plain periods that are high for floor(P/2) cycles. The data line is sampled in the last system cycle of each period. A 1 sampled in period index cfg_wait-1 or earlier (counting from 0) is taken as the start bit. If no start bit is seen by then, the response carries `rsp_timeout`.
- R8: After the start bit a read takes 8 data bits (most significant first) into `rsp_rdata`, then 4 check bits. `rsp_crc_err` is set when the received check differs from the value computed over the received data.
- R9: After a write command the block sends, PWM coded, a start bit of 1, the 8 data bits (most significant first) and their 4 check bits, followed by one plain period. From the second period on, the bit sampled in each period is compared with the bit sent one period earlier. Any mismatch sets `rsp_echo_err`.
- R10: Every accepted request produces exactly one single-cycle `rsp_valid`. A timeout response has both error flags clear. `rsp_rdata` is 0 for writes and for timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 8 | Extended register address; bit 7 selects the slave ID |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Data to write |
| cfg_period | input | PER_W | Clock period in system cycles, at least 10 |
| cfg_wait | input | WAIT_W | Maximum periods to wait for the slave, at least 1 |
| bus_clk_o | output | 1 | Clock line to the slave |
| bus_data_i | input | 1 | Data line from the slave |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Data read from the slave |
| rsp_crc_err | output | 1 | Read check value did not match |
| rsp_echo_err | output | 1 | Write echo did not match |
| rsp_timeout | output | 1 | Slave did not answer in time |

## Verification
Two events can fall on the same period boundary: the slave's start bit and the expiry of the wait count. The bench provokes this by delaying the start bit to period cfg_wait-1, where the start bit must win and the data must arrive intact, and then to period cfg_wait, where the response must be a bare timeout. During writes, the last echo sample and the end of the transaction share one boundary, so the bench also corrupts the echo of the final check bit and expects the error flag in that same response.

// File: rtl/regpwm_pkg.sv
package regpwm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENTER,
      ST_CMD,
      ST_WR,
      ST_RWAIT,
      ST_RDATA,
      ST_DONE
   } regpwm_state_e;

   typedef enum logic [1:0] {
      MODE_LOW,
      MODE_ZERO,
      MODE_ONE,
      MODE_PLAIN
   } regpwm_mode_e;

   localparam logic [3:0] CRC_POLY = 4'h3;

   function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
      logic fb;
      fb = c[3] ^ b;
      return {c[2:0], 1'b0} ^ (fb ? CRC_POLY : 4'h0);
   endfunction

   function automatic logic [3:0] crc4_calc(input logic [15:0] v, input int n);
      logic [3:0] c;
      c = 4'h0;
      for (int i = 15; i >= 0; i--) begin
         if (i < n) c = crc4_step(c, v[i]);
      end
      return c;
   endfunction

endpackage

// File: rtl/regpwm_sync.sv
module regpwm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("regpwm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/regpwm_crc4.sv
module regpwm_crc4 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       din,
   output logic [3:0] crc_o
);
   import regpwm_pkg::*;

   logic [3:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= 4'h0;
      else if (clr) crc_q <= 4'h0;
      else if (en)  crc_q <= crc4_step(crc_q, din);
   end

   assign crc_o = crc_q;

   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_o == 4'h0));
endmodule

// File: rtl/regpwm_bitgen.sv
module regpwm_bitgen
   import regpwm_pkg::*;
#(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  regpwm_mode_e     mode,
   input  logic [PER_W-1:0] period,
   input  logic [PER_W-1:0] h0,
   input  logic [PER_W-1:0] h1,
   output logic             line_o,
   output logic             tick_o
);
   generate
      if (PER_W < 4) begin : g_bad
         $error("regpwm_bitgen: PER_W too small");
      end
   endgenerate

   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] hsel;
   logic             line_q;

   always_comb begin
      case (mode)
         MODE_ZERO:  hsel = h0;
         MODE_ONE:   hsel = h1;
         MODE_PLAIN: hsel = period >> 1;
         default:    hsel = '0;
      endcase
   end

   assign tick_o = run && (cnt == period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         line_q <= 1'b1;
      end else begin
         if (!run || tick_o) cnt <= '0;
         else                cnt <= cnt + 1'b1;
         line_q <= run ? (cnt < hsel) : 1'b1;
      end
   end

   assign line_o = line_q;

   // checker: width of every high phase that started inside a run
   logic [PER_W-1:0] hw;
   logic             armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw    <= '0;
         armed <= 1'b0;
      end else begin
         hw    <= line_q ? hw + 1'b1 : '0;
         armed <= !run ? 1'b0 : (line_q ? armed : 1'b1);
      end
   end

   a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_q) && armed) |-> ((hw == h0) || (hw == h1) || (hw == (period >> 1))));
endmodule

// File: rtl/regpwm_master.sv
module regpwm_master
   import regpwm_pkg::*;
#(
   parameter int         PER_W       = 16,
   parameter int         WAIT_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] ID_BASE     = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [7:0]        req_addr,
   input  logic              req_write,
   input  logic [7:0]        req_wdata,
   input  logic [PER_W-1:0]  cfg_period,
   input  logic [WAIT_W-1:0] cfg_wait,
   output logic              bus_clk_o,
   input  logic              bus_data_i,
   output logic              rsp_valid,
   output logic [7:0]        rsp_rdata,
   output logic              rsp_crc_err,
   output logic              rsp_echo_err,
   output logic              rsp_timeout
);
   localparam int CMD_BITS = 16;
   localparam int WR_BITS  = 13;
   localparam int RD_BITS  = 12;
   localparam int BC_W     = $clog2(CMD_BITS + 1);
   localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_BITS - 1);
   localparam logic [BC_W-1:0] WR_LAST  = BC_W'(WR_BITS);
   localparam logic [BC_W-1:0] RD_LAST  = BC_W'(RD_BITS - 1);
   localparam logic [BC_W-1:0] RD_DATA  = BC_W'(8);
   localparam logic [PER_W-1:0] DIV5    = PER_W'(5);

   generate
      if (ID_BASE[0] != 1'b0) begin : g_bad_id
         $error("regpwm_master: ID_BASE must be even");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("regpwm_master: WAIT_W must be positive");
      end
   endgenerate

   regpwm_state_e      st;
   regpwm_mode_e       mode;
   logic               run;
   logic               tick;
   logic               data_s;
   logic [15:0]        shreg;
   logic [12:0]        eshr;
   logic [BC_W-1:0]    bitcnt;
   logic [WAIT_W-1:0]  waitcnt;
   logic [WAIT_W-1:0]  wait_q;
   logic [PER_W-1:0]   period_q, h0_q, h1_q;
   logic               is_wr;
   logic [7:0]         wdata_q;
   logic [10:0]        rx;
   logic [3:0]         crc_rx;
   logic               crc_clr, crc_en;
   logic [10:0]        cmd_pay;
   logic [2:0]         slave_id;
   logic [12:0]        wframe;
   logic               wait_end;

   regpwm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_data_i),
      .q     (data_s)
   );

   regpwm_bitgen #(.PER_W(PER_W)) u_bitgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .mode   (mode),
      .period (period_q),
      .h0     (h0_q),
      .h1     (h1_q),
      .line_o (bus_clk_o),
      .tick_o (tick)
   );

   regpwm_crc4 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (data_s),
      .crc_o (crc_rx)
   );

   assign slave_id = ID_BASE | {2'b00, req_addr[7]};
   assign cmd_pay  = {slave_id, req_addr[6:0], req_write};
   assign wframe   = {1'b1, wdata_q, crc4_calc({8'h00, wdata_q}, 8)};
   assign wait_end = (waitcnt == wait_q - 1'b1);

   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = (st == ST_DONE);
   assign crc_clr   = (st == ST_IDLE) && req_valid;
   assign crc_en    = (st == ST_RDATA) && tick && (bitcnt < RD_DATA);

   always_comb begin
      run  = 1'b0;
      mode = MODE_LOW;
      case (st)
         ST_ENTER: begin
            run  = 1'b1;
            mode = MODE_LOW;
         end
         ST_CMD: begin
            run  = 1'b1;
            mode = shreg[15] ? MODE_ONE : MODE_ZERO;
         end
         ST_WR: begin
            run = 1'b1;
            if (bitcnt < WR_LAST) mode = shreg[15] ? MODE_ONE : MODE_ZERO;
            else                  mode = MODE_PLAIN;
         end
         ST_RWAIT, ST_RDATA: begin
            run  = 1'b1;
            mode = MODE_PLAIN;
         end
         default: begin
            run  = 1'b0;
            mode = MODE_LOW;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         shreg        <= '0;
         eshr         <= '0;
         bitcnt       <= '0;
         waitcnt      <= '0;
         wait_q       <= '0;
         period_q     <= PER_W'(10);
         h0_q         <= PER_W'(2);
         h1_q         <= PER_W'(8);
         is_wr        <= 1'b0;
         wdata_q      <= '0;
         rx           <= '0;
         rsp_rdata    <= '0;
         rsp_crc_err  <= 1'b0;
         rsp_echo_err <= 1'b0;
         rsp_timeout  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  period_q     <= cfg_period;
                  h0_q         <= cfg_period / DIV5;
                  h1_q         <= cfg_period - cfg_period / DIV5;
                  wait_q       <= cfg_wait;
                  is_wr        <= req_write;
                  wdata_q      <= req_wdata;
                  shreg        <= {1'b1, cmd_pay, crc4_calc({5'b00000, cmd_pay}, 11)};
                  waitcnt      <= '0;
                  bitcnt       <= '0;
                  rsp_rdata    <= '0;
                  rsp_crc_err  <= 1'b0;
                  rsp_echo_err <= 1'b0;
                  rsp_timeout  <= 1'b0;
                  st           <= ST_ENTER;
               end
            end
            ST_ENTER: begin
               if (tick) begin
                  if (!data_s) begin
                     bitcnt <= '0;
                     st     <= ST_CMD;
                  end else if (wait_end) begin
                     rsp_timeout <= 1'b1;
                     st          <= ST_DONE;
                  end else begin
                     waitcnt <= waitcnt + 1'b1;
                  end
               end
            end
            ST_CMD: begin
               if (tick) begin
                  shreg  <= shreg << 1;
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == CMD_LAST) begin
                     bitcnt  <= '0;
                     waitcnt <= '0;
                     if (is_wr) begin
                        shreg <= {wframe, 3'b000};
                        eshr  <= wframe;
                        st    <= ST_WR;
                     end else begin
                        st    <= ST_RWAIT;
                     end
                  end
               end
            end
            ST_WR: begin
               if (tick) begin
                  shreg  <= shreg << 1;
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt != '0) begin
                     if (data_s != eshr[12]) rsp_echo_err <= 1'b1;
                     eshr <= eshr << 1;
                  end
                  if (bitcnt == WR_LAST) st <= ST_DONE;
               end
            end
            ST_RWAIT: begin
               if (tick) begin
                  if (data_s) begin
                     bitcnt <= '0;
                     st     <= ST_RDATA;
                  end else if (wait_end) begin
                     rsp_timeout <= 1'b1;
                     st          <= ST_DONE;
                  end else begin
                     waitcnt <= waitcnt + 1'b1;
                  end
               end
            end
            ST_RDATA: begin
               if (tick) begin
                  rx     <= {rx[9:0], data_s};
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == RD_LAST) begin
                     rsp_rdata   <= rx[10:3];
                     rsp_crc_err <= (crc_rx != {rx[2:0], data_s});
                     st          <= ST_DONE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st == ST_IDLE)) |-> bus_clk_o);

   a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r2_enter_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ENTER && $past(st == ST_ENTER)) |-> !bus_clk_o);

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_timeout) |-> (!rsp_crc_err && !rsp_echo_err && rsp_rdata == 8'h00));
endmodule

// File: tb/regpwm_master_tb.sv
module regpwm_master_tb;
   localparam int         P    = 50;
   localparam int         W    = 8;
   localparam logic [2:0] IDB  = 3'b010;
   localparam int         H0   = P / 5;
   localparam int         H1   = P - P / 5;
   localparam int         HP   = P / 2;

   typedef struct {
      logic [7:0] d;
      logic       ce;
      logic       ee;
      logic       to;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_addr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic [15:0] cfg_period = 16'(P);
   logic [15:0] cfg_wait = 16'(W);
   logic        bus_clk_o;
   logic        bus_data_i = 1'b1;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic        rsp_crc_err, rsp_echo_err, rsp_timeout;

   int   n_chk = 0;
   int   n_err = 0;
   int   n_rsp = 0;
   exp_t q[$];

   always #5 clk = ~clk;

   regpwm_master #(.PER_W(16), .WAIT_W(16), .SYNC_STAGES(2), .ID_BASE(IDB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .cfg_period(cfg_period), .cfg_wait(cfg_wait), .bus_clk_o(bus_clk_o),
      .bus_data_i(bus_data_i), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_crc_err(rsp_crc_err), .rsp_echo_err(rsp_echo_err), .rsp_timeout(rsp_timeout)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_crc(input logic [15:0] v, input int n);
      logic [3:0] c = 4'h0;
      for (int i = n - 1; i >= 0; i--) begin
         if ((c[3] ^ v[i]) == 1'b1) c = {c[2:0], 1'b0} ^ 4'b0011;
         else                       c = {c[2:0], 1'b0};
      end
      return c;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_rsp++;
         if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected response", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(rsp_rdata == e.d, "R8", "rdata", 32'(rsp_rdata), 32'(e.d));
            chk(rsp_crc_err == e.ce, "R8", "crc_err", 32'(rsp_crc_err), 32'(e.ce));
            chk(rsp_echo_err == e.ee, "R9", "echo_err", 32'(rsp_echo_err), 32'(e.ee));
            chk(rsp_timeout == e.to, "R7/R2 timeout", "timeout", 32'(rsp_timeout), 32'(e.to));
         end
      end
   end

   task automatic wait_rise();
      while (bus_clk_o) @(negedge clk);
      while (!bus_clk_o) @(negedge clk);
   endtask

   // waits for a rising edge, drives drv onto the data line, measures high width
   task automatic pulse(input logic drv, output int w);
      wait_rise();
      bus_data_i = drv;
      w = 1;
      @(negedge clk);
      while (bus_clk_o) begin
         w++;
         @(negedge clk);
      end
   endtask

   task automatic txn(input logic [7:0] addr, input logic wr, input logic [7:0] wd,
                      input int delay, input bit bad_crc, input int flip, input bit noack,
                      input logic [7:0] sd);
      exp_t        e;
      logic [2:0]  id;
      logic [10:0] pay;
      logic [15:0] fexp, fgot;
      logic [12:0] wf;
      logic [12:0] got;
      logic [11:0] rf;
      int          w, n0;
      bit          wok;

      id   = IDB + {2'b00, addr[7]};
      pay  = {id, addr[6:0], wr};
      fexp = {1'b1, pay, ref_crc({5'b0, pay}, 11)};
      e.d  = 8'h00; e.ce = 1'b0; e.ee = 1'b0; e.to = 1'b0;
      if (noack || (!wr && delay >= W)) e.to = 1'b1;
      else if (!wr) begin
         e.d  = sd;
         e.ce = bad_crc;
      end else if (flip >= 0) e.ee = 1'b1;
      q.push_back(e);
      n0 = n_rsp;

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R1", "ready while busy", 32'(req_ready), 32'd0);

      while (bus_clk_o) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!bus_clk_o, "R2", "clock held low before ack", 32'(bus_clk_o), 32'd0);

      if (!noack) begin
         bus_data_i = 1'b0;
         wok  = 1'b1;
         fgot = '0;
         for (int i = 15; i >= 0; i--) begin
            pulse(1'b0, w);
            fgot[i] = (w > HP);
            if (w != (fgot[i] ? H1 : H0)) wok = 1'b0;
         end
         chk(wok, "R3", "command pulse widths", 32'(wok), 32'd1);
         chk(fgot == fexp, "R4 R5 R6", "command frame", 32'(fgot), 32'(fexp));

         if (wr) begin
            wf  = {1'b1, wd, ref_crc({8'b0, wd}, 8)};
            wok = 1'b1;
            pulse(1'b0, w);
            got[12] = (w > HP);
            if (w != (got[12] ? H1 : H0)) wok = 1'b0;
            for (int k = 11; k >= 0; k--) begin
               pulse(((12 - (k + 1)) == flip) ? ~got[k+1] : got[k+1], w);
               got[k] = (w > HP);
               if (w != (got[k] ? H1 : H0)) wok = 1'b0;
            end
            pulse((flip == 12) ? ~got[0] : got[0], w);
            chk(w == HP, "R9", "final plain period width", 32'(w), 32'(HP));
            chk(wok, "R3", "write pulse widths", 32'(wok), 32'd1);
            chk(got == wf, "R9 R5", "write frame", 32'(got), 32'(wf));
         end else if (delay < W) begin
            rf = {sd, ref_crc({8'b0, sd}, 8) ^ (bad_crc ? 4'b0001 : 4'b0000)};
            repeat (delay) wait_rise();
            wait_rise();
            bus_data_i = 1'b1;
            for (int k = 11; k >= 0; k--) begin
               wait_rise();
               bus_data_i = rf[k];
            end
         end
      end

      while (n_rsp == n0) @(negedge clk);
      bus_data_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(bus_clk_o && req_ready, "R1 R10", "idle after response",
          32'({bus_clk_o, req_ready}), 32'h3);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_clk_o == 1'b1, "R1", "reset clock level", 32'(bus_clk_o), 32'd1);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", "no response at rest", 32'(rsp_valid), 32'd0);

      txn(8'h78, 1'b0, 8'h00, 2, 1'b0, -1, 1'b0, 8'hA5);      // R7 R8 read
      txn(8'hF3, 1'b0, 8'h00, 0, 1'b0, -1, 1'b0, 8'h3C);      // R6 upper id
      txn(8'h15, 1'b1, 8'h96, 0, 1'b0, -1, 1'b0, 8'h00);      // R9 clean write
      txn(8'h9A, 1'b1, 8'h01, 0, 1'b0, 5, 1'b0, 8'h00);       // R9 echo mismatch mid
      txn(8'h42, 1'b0, 8'h00, 1, 1'b1, -1, 1'b0, 8'h5A);      // R8 bad check
      txn(8'h07, 1'b0, 8'h00, W - 1, 1'b0, -1, 1'b0, 8'hC3);  // R7 start on last period
      txn(8'h07, 1'b0, 8'h00, W, 1'b0, -1, 1'b0, 8'h00);      // R7 timeout boundary
      txn(8'h11, 1'b0, 8'h00, 0, 1'b0, -1, 1'b1, 8'h00);      // R2 no ack
      txn(8'hE0, 1'b1, 8'hFF, 0, 1'b0, 12, 1'b0, 8'h00);      // R9 last echo bad
      txn(8'h80, 1'b0, 8'h00, 1, 1'b0, -1, 1'b0, 8'hFF);      // R8 all ones

      repeat (10) @(negedge clk);
      chk(q.size() == 0, "R10", "responses outstanding", 32'(q.size()), 32'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule